// File: doc/BRIEF.md
# Boot Image Overlay Swap Controller

This block sits next to an 8-bit CPU. It watches the CPU's I/O write cycles and responds to two port numbers that control whether the boot image is overlaid on low memory.

A write to the "unmap" port clears the overlay flag. A write to the "restore" port starts a bus-mastered copy. For that copy the block requests the CPU bus and waits for the grant. It then streams a stored boot image out of a synchronous ROM into the lowest 2 KB of SRAM, one byte per clock. When the copy is done it hands the bus back and raises the overlay flag again.

Every I/O write to either of the two ports gets an acknowledge pulse, so the CPU never waits forever in its I/O cycle. Writes to any other port are left alone for other devices to answer. The data byte of an I/O write has no meaning to this block, so it is not an input.

Top module: `bootswap_ctrl`

## Requirements
- R1: After reset, `overlay_on` is 1, `busrq_n` is 1, `io_ack` is 0 and `sram_we` is 0.
- R2: An I/O write (`io_wr` high for one cycle) to port 0x38 clears `overlay_on` from the second cycle after the strobe cycle on.
- R3: An I/O write to port 0x38 or 0x39 makes `io_ack` high for exactly the one cycle after the strobe cycle. This holds even while a copy is running.
- R4: An I/O write to any port other than 0x38 and 0x39 gives no `io_ack`, does not change `overlay_on`, and does not start a bus request.
- R5: A write to port 0x39 while idle drives `busrq_n` low from the second cycle after the strobe. No SRAM write occurs until `busak_n` has been seen low.
- R6: After the grant, exactly 2048 SRAM writes happen in consecutive cycles at addresses 0x000 to 0x7FF in ascending order. The ROM has a one-cycle read latency: the data for address A appears on `rom_rdata` the cycle after `rom_addr` = A. Each write's data is that returned ROM byte.
- R7: In the cycle after the last SRAM write, `busrq_n` returns to 1 and `overlay_on` is 1.
- R8: A port 0x39 write that arrives while a copy is in progress is acknowledged but otherwise ignored. The copy still makes exactly 2048 writes, and no second bus request follows it.
- R9: `sram_we` is high only while both `busrq_n` and `busak_n` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | One-cycle strobe: CPU I/O write |
| io_port | input | 8 | I/O port number of the write |
| io_ack | output | 1 | Acknowledge pulse for a decoded port |
| busrq_n | output | 1 | Active-low bus request to the CPU |
| busak_n | input | 1 | Active-low bus grant from the CPU |
| rom_addr | output | 11 | Boot image ROM read address |
| rom_rdata | input | 8 | ROM read data, one cycle after the address |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 11 | SRAM write address |
| sram_wdata | output | 8 | SRAM write data |
| overlay_on | output | 1 | Boot image overlay is active |

## Verification
The hardest situation to reach is a second restore write that lands inside a running copy. The bench reaches it by starting a copy and then watching its own write counter. Once a few hundred bytes have passed, it issues the 0x39 write. It then confirms that the byte stream stays unbroken and that no new bus request appears once the bus is released. The window between request and grant is stretched with a random grant delay, including zero and long delays, to show that nothing is written before the bus is owned.

// File: rtl/bootswap_pkg.sv
// Package: shared types for the boot image overlay swap controller.
// Assumes: nothing beyond standard SystemVerilog.
package bootswap_pkg;

    // Copy engine sequencing states
    typedef enum logic [1:0] {
        CP_IDLE  = 2'd0,
        CP_REQ   = 2'd1,
        CP_COPY  = 2'd2,
        CP_FLUSH = 2'd3
    } cp_state_t;

endpackage

// File: rtl/bsw_io_decode.sv
// Module: bsw_io_decode
// Decodes CPU I/O write strobes against the two control ports. It gives a
// registered acknowledge and one-cycle hit pulses for each port.
// Assumes: io_wr is a single-cycle strobe per I/O write.
module bsw_io_decode #(
    parameter int          PW       = 8,
    parameter logic [PW-1:0] PORT_OFF = 8'h38,
    parameter logic [PW-1:0] PORT_ON  = 8'h39
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic [PW-1:0] io_port,
    output logic          io_ack,
    output logic          off_hit,
    output logic          on_hit
);

    logic is_off;
    logic is_on;

    // Purpose: compare the strobed port against both control ports
    always_comb begin
        is_off = (io_port == PORT_OFF);
        is_on  = (io_port == PORT_ON);
    end

    // Purpose: register the acknowledge and the per-port hit pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_ack  <= 1'b0;
            off_hit <= 1'b0;
            on_hit  <= 1'b0;
        end else begin
            io_ack  <= io_wr && (is_off || is_on);
            off_hit <= io_wr && is_off;
            on_hit  <= io_wr && is_on;
        end
    end

endmodule

// File: rtl/bsw_copy_engine.sv
// Module: bsw_copy_engine
// Requests the bus, waits for the grant and copies 2**AW bytes from a
// synchronous ROM into SRAM in ascending order, then releases the bus.
// Assumes: the ROM returns data one cycle after the address. A start pulse
// that arrives outside the idle state is dropped.
module bsw_copy_engine
    import bootswap_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          busak_n,
    output logic          busrq_n,
    output logic [AW-1:0] rom_addr,
    output logic          sram_we,
    output logic [AW-1:0] sram_addr,
    output logic          done
);

    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    cp_state_t     state;
    logic [AW-1:0] cnt;
    logic          wr_v;
    logic [AW-1:0] wr_addr;

    // Purpose: sequence request, grant wait, read stream and final write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CP_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                CP_IDLE:  if (start) state <= CP_REQ;
                CP_REQ:   if (!busak_n) begin
                              state <= CP_COPY;
                              cnt   <= '0;
                          end
                CP_COPY:  begin
                              cnt <= cnt + 1'b1;
                              if (cnt == LAST) state <= CP_FLUSH;
                          end
                CP_FLUSH: state <= CP_IDLE;
                default:  state <= CP_IDLE;
            endcase
        end
    end

    // Purpose: delay each issued read by the ROM latency to form the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_v    <= 1'b0;
            wr_addr <= '0;
        end else begin
            wr_v    <= (state == CP_COPY);
            wr_addr <= cnt;
        end
    end

    // Purpose: drive the engine outputs from its registers
    always_comb begin
        busrq_n   = (state == CP_IDLE);
        rom_addr  = cnt;
        sram_we   = wr_v;
        sram_addr = wr_addr;
        done      = (state == CP_FLUSH);
    end

endmodule

// File: rtl/bootswap_ctrl.sv
// Module: bootswap_ctrl (top)
// Overlay control for the boot image. Port PORT_OFF clears the overlay flag.
// Port PORT_ON restores the image into low SRAM by a bus-mastered copy and
// then sets the flag.
// Assumes: single-cycle io_wr strobes and a ROM with one cycle of read latency.
module bootswap_ctrl #(
    parameter int             AW       = 11,
    parameter int             DW       = 8,
    parameter int             PW       = 8,
    parameter logic [PW-1:0]  PORT_OFF = 8'h38,
    parameter logic [PW-1:0]  PORT_ON  = 8'h39
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic [PW-1:0] io_port,
    output logic          io_ack,
    output logic          busrq_n,
    input  logic          busak_n,
    output logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_rdata,
    output logic          sram_we,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    output logic          overlay_on
);

    logic off_hit;
    logic on_hit;
    logic done;

    bsw_io_decode #(
        .PW       (PW),
        .PORT_OFF (PORT_OFF),
        .PORT_ON  (PORT_ON)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_port (io_port),
        .io_ack  (io_ack),
        .off_hit (off_hit),
        .on_hit  (on_hit)
    );

    bsw_copy_engine #(
        .AW (AW)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (on_hit),
        .busak_n   (busak_n),
        .busrq_n   (busrq_n),
        .rom_addr  (rom_addr),
        .sram_we   (sram_we),
        .sram_addr (sram_addr),
        .done      (done)
    );

    // Purpose: ROM data arrives aligned with the delayed write strobe
    assign sram_wdata = rom_rdata;

    // Purpose: hold the overlay flag; copy completion wins over an unmap write
    always_ff @(posedge clk) begin
        if (!rst_n)       overlay_on <= 1'b1;
        else if (done)    overlay_on <= 1'b1;
        else if (off_hit) overlay_on <= 1'b0;
    end

endmodule

// File: rtl/bootswap_ctrl_chk.sv
// Module: bootswap_ctrl_chk
// Temporal checks on the overlay swap controller ports, bound to the top.
// Assumes: the same port encodings as the top module parameters.
module bootswap_ctrl_chk #(
    parameter int            AW       = 11,
    parameter int            PW       = 8,
    parameter logic [PW-1:0] PORT_OFF = 8'h38,
    parameter logic [PW-1:0] PORT_ON  = 8'h39
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_wr,
    input logic [PW-1:0] io_port,
    input logic          io_ack,
    input logic          busrq_n,
    input logic          busak_n,
    input logic          sram_we,
    input logic [AW-1:0] sram_addr,
    input logic          overlay_on
);

    // R3
    ack_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && (io_port == PORT_OFF || io_port == PORT_ON) |=> io_ack);

    // R4
    ack_only_decoded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> $past(io_wr) && ($past(io_port) == PORT_OFF || $past(io_port) == PORT_ON));

    // R9
    write_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (!busrq_n && !busak_n));

    // R6
    addr_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we && $past(sram_we) |-> sram_addr == AW'($past(sram_addr) + 1'b1));

    // R6
    first_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we) |-> sram_addr == '0);

    // R7
    release_sets_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busrq_n) |-> overlay_on);

endmodule

bind bootswap_ctrl bootswap_ctrl_chk #(
    .AW       (AW),
    .PW       (PW),
    .PORT_OFF (PORT_OFF),
    .PORT_ON  (PORT_ON)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_port    (io_port),
    .io_ack     (io_ack),
    .busrq_n    (busrq_n),
    .busak_n    (busak_n),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .overlay_on (overlay_on)
);

// File: tb/bootswap_ctrl_tb.sv
module bootswap_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = 8'h00;
    logic        io_ack;
    logic        busrq_n;
    logic        busak_n = 1'b1;
    logic [10:0] rom_addr;
    logic [7:0]  rom_rdata = 8'h00;
    logic        sram_we;
    logic [10:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic        overlay_on;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int gdelay = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    bootswap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
        .io_ack(io_ack), .busrq_n(busrq_n), .busak_n(busak_n),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .overlay_on(overlay_on)
    );

    // Boot image contents as a function of address
    function automatic logic [7:0] rom_f(input logic [10:0] a);
        logic [15:0] t;
        t = 16'(a) * 16'd37;
        return t[7:0] ^ a[10:3];
    endfunction

    // Synchronous ROM model, one-cycle latency
    always @(posedge clk) rom_rdata <= rom_f(rom_addr);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // SRAM write monitor: R6 address/data, R9 bus ownership
    always @(negedge clk) begin
        if (rst_n && sram_we) begin
            chk(sram_addr == 11'(wr_count), "R6 write address", int'(sram_addr), wr_count % 2048);
            chk(sram_wdata == rom_f(sram_addr), "R6 write data", int'(sram_wdata), int'(rom_f(sram_addr)));
            chk(!busak_n && !busrq_n, "R9 bus owned during write", int'({busrq_n, busak_n}), 0);
            wr_count++;
        end
    end

    // CPU bus grant model with programmable delay
    initial begin
        forever begin
            @(negedge clk);
            if (!busrq_n && busak_n) begin
                repeat (gdelay) @(negedge clk);
                busak_n = 1'b0;
            end else if (busrq_n) begin
                busak_n = 1'b1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            chk(0, "watchdog expired", 0, 1);
            summary();
        end
    end

    // Issue one I/O write; returns the ack seen in the following cycle
    task automatic io_write(input logic [7:0] p, output bit ack);
        @(negedge clk);
        io_wr = 1'b1;
        io_port = p;
        @(negedge clk);
        io_wr = 1'b0;
        ack = io_ack;
    endtask

    // Restore sequence with full checking
    task automatic run_copy(input int delay, input string tag);
        bit ack;
        int base;
        int guard;
        gdelay = delay;
        base = wr_count;
        io_write(8'h39, ack);
        chk(ack, {"R3 ack 0x39 ", tag}, int'(ack), 1);
        @(negedge clk);
        chk(!busrq_n, {"R5 request raised ", tag}, int'(busrq_n), 0);
        chk(wr_count == base, {"R5 no write before grant ", tag}, wr_count - base, 0);
        guard = 0;
        while (!busrq_n && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(busrq_n, {"R7 bus released ", tag}, int'(busrq_n), 1);
        chk(overlay_on, {"R7 overlay set ", tag}, int'(overlay_on), 1);
        chk(wr_count - base == 2048, {"R6 byte count ", tag}, wr_count - base, 2048);
    endtask

    initial begin
        bit ack;
        bit exp_ov;
        int base;
        void'($urandom(32'd914));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(overlay_on, "R1 overlay after reset", int'(overlay_on), 1);
        chk(busrq_n, "R1 busrq_n after reset", int'(busrq_n), 1);
        chk(!io_ack, "R1 io_ack after reset", int'(io_ack), 0);
        chk(!sram_we, "R1 sram_we after reset", int'(sram_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 unmap write
        io_write(8'h38, ack);
        chk(ack, "R3 ack 0x38", int'(ack), 1);
        @(negedge clk);
        chk(!io_ack, "R3 ack lasts one cycle", int'(io_ack), 0);
        chk(!overlay_on, "R2 overlay cleared", int'(overlay_on), 0);
        exp_ov = 0;

        // R5/R6/R7 restore, zero and long grant delay
        run_copy(0, "delay0");
        exp_ov = 1;
        io_write(8'h38, ack);
        @(negedge clk);
        chk(!overlay_on, "R2 overlay cleared again", int'(overlay_on), 0);
        run_copy(15, "delay15");

        // R8 restore write during copy
        gdelay = 2;
        base = wr_count;
        io_write(8'h39, ack);
        while (wr_count - base < 300) @(negedge clk);
        io_write(8'h39, ack);
        chk(ack, "R8 mid-copy write acked", int'(ack), 1);
        while (!busrq_n) @(negedge clk);
        chk(wr_count - base == 2048, "R8 single copy length", wr_count - base, 2048);
        repeat (6) @(negedge clk);
        chk(busrq_n, "R8 no second request", int'(busrq_n), 1);
        chk(wr_count - base == 2048, "R8 no extra writes", wr_count - base, 2048);

        // Random port writes against a bench model (R2, R3, R4)
        for (int i = 0; i < 40; i++) begin
            logic [7:0] p;
            int sel;
            sel = $urandom_range(0, 9);
            p = 8'($urandom_range(0, 255));
            if (sel == 0) p = 8'h38;
            if (sel == 1) p = 8'h39;
            if (p == 8'h39) begin
                run_copy($urandom_range(0, 12), "random");
                exp_ov = 1;
            end else begin
                io_write(p, ack);
                @(negedge clk);
                if (p == 8'h38) begin
                    exp_ov = 0;
                    chk(ack, "R3 random 0x38 ack", int'(ack), 1);
                end else begin
                    chk(!ack, "R4 other port no ack", int'(ack), 0);
                    chk(busrq_n, "R4 other port no request", int'(busrq_n), 1);
                end
                chk(overlay_on == exp_ov, "R2/R4 overlay model", int'(overlay_on), int'(exp_ov));
            end
        end

        done_flag = 1;
        summary();
    end

endmodule